// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address. It searches a small, fully associative set of translation slots, and every slot is compared at the same time. Each slot covers two neighbouring 4 KiB pages: the even page and the odd page. For each page a slot keeps its own frame number, a valid flag and a dirty flag. A slot also carries a global flag and an 8-bit address-space identifier. A slot hits only if both of these hold:

- its page-pair tag equals virtual address bits 31:13;
- it is global, or its identifier equals the low byte of the current context word.

Address bit 12 then picks the half of the slot that applies.

A lookup is a one-cycle strobe carrying the address, a write flag and the context word. One cycle later the registered result appears: a result code, the physical address, and read and write permission. Software fills slots through a separate write port, which takes a slot index and the complete slot contents.

The result code uses 3 bits: 0 = match, 1 = bad address, 2 = no match, 3 = invalid, 4 = dirty. Code 1 is reserved for an address-range check that lies outside this block, so this block never produces it.

Top module: `tlb_lookup_top`

## Requirements
- R1: A slot written through the write port in cycle N is seen by lookups strobed in cycle N+1 and later. A lookup strobed in cycle N itself sees the previous contents of that slot. Rewriting a slot replaces all of its fields.
- R2: After reset no slot is live, so every lookup returns code 2 (no match).
- R3: A slot hits only when both conditions hold:
  - its tag equals virtual address bits 31:13;
  - its global flag is 1, or its identifier equals bits 7:0 of the context word (bits 31:8 of the context word are ignored).

  When no live slot hits, the result is code 2, with physical address 0 and both permissions 0.
- R4: Address bit 12 selects a half of the hit slot: 0 selects the even half and 1 selects the odd half. The physical address is {frame number of that half, virtual address bits 11:0}.
- R5: If the valid flag of the selected half is 0, the result is code 3 (invalid) for reads and for writes, with physical address 0 and both permissions 0.
- R6: A write lookup to a valid half whose dirty flag is 0 returns code 4 (dirty), with physical address 0 and both permissions 0.
- R7: Every other hit returns code 0 (match). Read permission is 1, and write permission equals the dirty flag of the selected half.
- R8: When several live slots hit, the slot with the lowest index supplies the result.
- R9: The result valid output rises exactly one cycle after each lookup strobe and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| lk_ctx | input | 32 | Context word; bits 7:0 hold the current address-space identifier |
| fill_en | input | 1 | Slot write strobe |
| fill_idx | input | 4 | Index of the slot to write |
| fill_tag | input | 19 | Page-pair tag (virtual address bits 31:13) |
| fill_asid | input | 8 | Address-space identifier of the slot |
| fill_glob | input | 1 | Global flag of the slot |
| fill_pfn_e | input | 20 | Frame number of the even half |
| fill_v_e | input | 1 | Valid flag of the even half |
| fill_d_e | input | 1 | Dirty flag of the even half |
| fill_pfn_o | input | 20 | Frame number of the odd half |
| fill_v_o | input | 1 | Valid flag of the odd half |
| fill_d_o | input | 1 | Dirty flag of the odd half |
| rs_valid | output | 1 | Result valid, one cycle after the strobe |
| rs_code | output | 3 | Result code (0 match, 2 no match, 3 invalid, 4 dirty) |
| rs_paddr | output | 32 | Physical address, 0 unless the code is match |
| rs_rd_ok | output | 1 | Read permission |
| rs_wr_ok | output | 1 | Write permission |

## Verification
The lookup is tried with several stimulus groups, each separating a different pair of outcomes:

- Loads and stores to both halves of one slot, which separate the match and dirty codes and the even and odd frames.
- Identifiers that differ only in the low byte, or only in the upper bits of the context word, which show whether the identifier compare looks at the right bits.
- A global slot with one invalid half, which separates invalid from no match, and which also shows that the global flag overrides an identifier mismatch.
- Two live slots with equal tags, before and after the lower one is retagged, which exposes the priority order.
- A fill and a lookup in the same cycle followed by a repeat lookup, which pins down when a write becomes visible.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PG_BITS = 12;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = VA_W - PG_BITS;
  localparam int TAG_W   = VA_W - PG_BITS - 1;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_BADADDR = 3'd1,
    RES_NOMATCH = 3'd2,
    RES_INVALID = 3'd3,
    RES_DIRTY   = 3'd4
  } res_code_e;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn_e;
    logic              v_e;
    logic              d_e;
    logic [PFN_W-1:0]  pfn_o;
    logic              v_o;
    logic              d_o;
  } slot_t;
endpackage

// File: rtl/tlb_slot_store.sv
module tlb_slot_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  slot_t                   wdata,
  output slot_t [ENTRIES-1:0]     slots,
  output logic  [ENTRIES-1:0]     live
);
  // Every slot feeds a comparator each cycle, so storage is flops, not RAM.
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (we && widx == IDX_W'(i)) slots[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (we && widx == IDX_W'(i)) live[i] <= 1'b1;
      end
    end
  end

  AST_FILL_LIVE: assert property (@(posedge clk) disable iff (rst)
    we |=> live[$past(widx)]); // R1
  AST_FILL_DATA: assert property (@(posedge clk) disable iff (rst)
    we |=> slots[$past(widx)] == $past(wdata)); // R1
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  slot_t [ENTRIES-1:0] slots,
  input  logic  [ENTRIES-1:0] live,
  input  logic  [VA_W-1:0]    vaddr,
  input  logic  [ASID_W-1:0]  asid,
  output logic                hit_any,
  output logic  [IDX_W-1:0]   sel_idx,
  output slot_t               sel_slot
);
  logic [ENTRIES-1:0] hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = live[g]
                  && (slots[g].tag == vaddr[VA_W-1:PG_BITS+1])
                  && (slots[g].glob || slots[g].asid == asid);
  end

  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) sel_idx = IDX_W'(i);
    end
  end

  assign hit_any  = |hit;
  assign sel_slot = slots[sel_idx];

  AST_PICKED_HITS: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> hit[sel_idx]); // R8
  AST_NONE_BELOW: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (hit & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0); // R8
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
(
  input  logic            hit_any,
  input  slot_t           slot,
  input  logic [VA_W-1:0] vaddr,
  input  logic            is_wr,
  output res_code_e       code,
  output logic [VA_W-1:0] paddr,
  output logic            rd_ok,
  output logic            wr_ok
);
  logic             odd;
  logic [PFN_W-1:0] pfn;
  logic             v, d;

  assign odd = vaddr[PG_BITS];
  assign pfn = odd ? slot.pfn_o : slot.pfn_e;
  assign v   = odd ? slot.v_o   : slot.v_e;
  assign d   = odd ? slot.d_o   : slot.d_e;

  always_comb begin
    code  = RES_MATCH;
    paddr = '0;
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    if (!hit_any) begin
      code = RES_NOMATCH;
    end else if (!v) begin
      code = RES_INVALID;
    end else if (is_wr && !d) begin
      code = RES_DIRTY;
    end else begin
      paddr = {pfn, vaddr[PG_BITS-1:0]};
      rd_ok = 1'b1;
      wr_ok = d;
    end
  end
endmodule

// File: rtl/tlb_lookup_top.sv
module tlb_lookup_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic [VA_W-1:0]   lk_ctx,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_glob,
  input  logic [PFN_W-1:0]  fill_pfn_e,
  input  logic              fill_v_e,
  input  logic              fill_d_e,
  input  logic [PFN_W-1:0]  fill_pfn_o,
  input  logic              fill_v_o,
  input  logic              fill_d_o,
  output logic              rs_valid,
  output logic [2:0]        rs_code,
  output logic [VA_W-1:0]   rs_paddr,
  output logic              rs_rd_ok,
  output logic              rs_wr_ok
);
  slot_t                fill_slot;
  slot_t [ENTRIES-1:0]  slots;
  logic  [ENTRIES-1:0]  live;
  logic                 hit_any;
  logic  [IDX_W-1:0]    sel_idx;
  slot_t                sel_slot;
  res_code_e            nxt_code;
  logic  [VA_W-1:0]     nxt_paddr;
  logic                 nxt_rd, nxt_wr;

  assign fill_slot = '{tag: fill_tag, asid: fill_asid, glob: fill_glob,
                       pfn_e: fill_pfn_e, v_e: fill_v_e, d_e: fill_d_e,
                       pfn_o: fill_pfn_o, v_o: fill_v_o, d_o: fill_d_o};

  tlb_slot_store #(.ENTRIES(ENTRIES)) store_i (
    .clk(clk), .rst(rst), .we(fill_en), .widx(fill_idx), .wdata(fill_slot),
    .slots(slots), .live(live)
  );

  tlb_match #(.ENTRIES(ENTRIES)) match_i (
    .clk(clk), .rst(rst), .slots(slots), .live(live), .vaddr(lk_vaddr),
    .asid(lk_ctx[ASID_W-1:0]), .hit_any(hit_any), .sel_idx(sel_idx),
    .sel_slot(sel_slot)
  );

  tlb_resolve resolve_i (
    .hit_any(hit_any), .slot(sel_slot), .vaddr(lk_vaddr), .is_wr(lk_write),
    .code(nxt_code), .paddr(nxt_paddr), .rd_ok(nxt_rd), .wr_ok(nxt_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_code  <= RES_NOMATCH;
      rs_paddr <= '0;
      rs_rd_ok <= 1'b0;
      rs_wr_ok <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_code  <= nxt_code;
        rs_paddr <= nxt_paddr;
        rs_rd_ok <= nxt_rd;
        rs_wr_ok <= nxt_wr;
      end
    end
  end

  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid); // R9
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid); // R9
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_code != 3'd0) |-> (!rs_rd_ok && !rs_wr_ok && rs_paddr == '0)); // R5
  AST_WR_IMPLIES_RD: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_wr_ok) |-> (rs_rd_ok && rs_code == 3'd0)); // R7
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && nxt_code == RES_MATCH) |=> rs_paddr[PG_BITS-1:0] == $past(lk_vaddr[PG_BITS-1:0])); // R4
  AST_STORE_NEEDS_D: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_write && nxt_code == RES_MATCH) |=> rs_wr_ok); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> (rs_code inside {3'd0, 3'd2, 3'd3, 3'd4})); // R7
endmodule

// File: tb/tlb_lookup_top_tb_top.sv
module tlb_lookup_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0, lk_ctx = '0;
  logic        fill_en = 1'b0;
  logic [3:0]  fill_idx = '0;
  logic [18:0] fill_tag = '0;
  logic [7:0]  fill_asid = '0;
  logic        fill_glob = 1'b0;
  logic [19:0] fill_pfn_e = '0, fill_pfn_o = '0;
  logic        fill_v_e = 1'b0, fill_d_e = 1'b0, fill_v_o = 1'b0, fill_d_o = 1'b0;
  logic        rs_valid, rs_rd_ok, rs_wr_ok;
  logic [2:0]  rs_code;
  logic [31:0] rs_paddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tlb_lookup_top dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_ctx(lk_ctx), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_asid(fill_asid), .fill_glob(fill_glob),
    .fill_pfn_e(fill_pfn_e), .fill_v_e(fill_v_e), .fill_d_e(fill_d_e),
    .fill_pfn_o(fill_pfn_o), .fill_v_o(fill_v_o), .fill_d_o(fill_d_o),
    .rs_valid(rs_valid), .rs_code(rs_code), .rs_paddr(rs_paddr),
    .rs_rd_ok(rs_rd_ok), .rs_wr_ok(rs_wr_ok)
  );

  typedef struct {
    logic [2:0]  code;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    string       req;
  } exp_t;
  exp_t q[$];

  // Reference slot contents, kept from the requirement text
  logic [18:0] m_tag[16];
  logic [7:0]  m_asid[16];
  logic        m_g[16], m_live[16];
  logic [19:0] m_pe[16], m_po[16];
  logic        m_ve[16], m_de[16], m_vo[16], m_do[16];

  function automatic exp_t predict(input logic [31:0] va, input logic w,
                                   input logic [31:0] ctx, input string req);
    exp_t e;
    bit found = 1'b0;
    e.code = 3'd2; e.pa = '0; e.rd = 1'b0; e.wr = 1'b0; e.req = req;
    for (int i = 0; i < 16; i++) begin
      if (!found && m_live[i] && m_tag[i] == va[31:13]
          && (m_g[i] || m_asid[i] == ctx[7:0])) begin
        logic [19:0] f; logic v, d;
        found = 1'b1;
        f = va[12] ? m_po[i] : m_pe[i];
        v = va[12] ? m_vo[i] : m_ve[i];
        d = va[12] ? m_do[i] : m_de[i];
        if (!v) e.code = 3'd3;
        else if (w && !d) e.code = 3'd4;
        else begin
          e.code = 3'd0; e.pa = {f, va[11:0]}; e.rd = 1'b1; e.wr = d;
        end
      end
    end
    return e;
  endfunction

  task automatic defaults();
    lk_valid = 1'b0; fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic w,
                        input logic [31:0] ctx, input string req);
    @(negedge clk);
    defaults();
    lk_valid = 1'b1; lk_vaddr = va; lk_write = w; lk_ctx = ctx;
    q.push_back(predict(va, w, ctx, req));
  endtask

  task automatic set_fill(input int idx, input logic [31:0] va_pair, input logic [7:0] asid,
                          input logic g, input logic [19:0] pe, input logic ve, input logic de,
                          input logic [19:0] po, input logic vo, input logic dd);
    fill_en = 1'b1; fill_idx = 4'(idx); fill_tag = va_pair[31:13]; fill_asid = asid;
    fill_glob = g; fill_pfn_e = pe; fill_v_e = ve; fill_d_e = de;
    fill_pfn_o = po; fill_v_o = vo; fill_d_o = dd;
  endtask

  task automatic model_fill(input int idx, input logic [31:0] va_pair, input logic [7:0] asid,
                            input logic g, input logic [19:0] pe, input logic ve, input logic de,
                            input logic [19:0] po, input logic vo, input logic dd);
    m_live[idx] = 1'b1; m_tag[idx] = va_pair[31:13]; m_asid[idx] = asid; m_g[idx] = g;
    m_pe[idx] = pe; m_ve[idx] = ve; m_de[idx] = de;
    m_po[idx] = po; m_vo[idx] = vo; m_do[idx] = dd;
  endtask

  task automatic fill(input int idx, input logic [31:0] va_pair, input logic [7:0] asid,
                      input logic g, input logic [19:0] pe, input logic ve, input logic de,
                      input logic [19:0] po, input logic vo, input logic dd);
    @(negedge clk);
    defaults();
    set_fill(idx, va_pair, asid, g, pe, ve, de, po, vo, dd);
    model_fill(idx, va_pair, asid, g, pe, ve, de, po, vo, dd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      defaults();
    end
  endtask

  // Monitor: pops one expectation per result and compares it
  always @(negedge clk) begin
    if (!rst && !finished && rs_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected result code=%0d expected no result", rs_code);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rs_code !== e.code || rs_paddr !== e.pa || rs_rd_ok !== e.rd || rs_wr_ok !== e.wr) begin
          bad++;
          $display("FAIL %s: code=%0d pa=%h rd=%0b wr=%0b expected code=%0d pa=%h rd=%0b wr=%0b",
                   e.req, rs_code, rs_paddr, rs_rd_ok, rs_wr_ok, e.code, e.pa, e.rd, e.wr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model_fill(i, 32'h0, 8'h0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) m_live[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (rs_valid !== 1'b0) begin
      bad++;
      $display("FAIL R9: rs_valid=%0b after reset expected 0", rs_valid);
    end

    lookup(32'h0000_0000, 1'b0, 32'h0, "R2 reset empty");
    lookup(32'h0040_2abc, 1'b1, 32'h5, "R2 reset empty store");

    fill(3, 32'h0040_2000, 8'h05, 1'b0, 20'h11111, 1'b1, 1'b1, 20'h22222, 1'b1, 1'b0);
    lookup(32'h0040_2abc, 1'b0, 32'h5, "R4 R7 even load");
    lookup(32'h0040_3123, 1'b0, 32'h5, "R4 R7 odd load clean");
    lookup(32'h0040_3123, 1'b1, 32'h5, "R6 odd store clean");
    lookup(32'h0040_2fff, 1'b1, 32'h5, "R7 even store dirty");
    lookup(32'h0040_2abc, 1'b0, 32'h6, "R3 asid mismatch");
    lookup(32'h0040_4abc, 1'b0, 32'h5, "R3 tag mismatch");
    lookup(32'h0040_2abc, 1'b0, 32'hABCD_E005, "R3 upper ctx ignored");

    fill(7, 32'h1000_0000, 8'h09, 1'b1, 20'h33333, 1'b0, 1'b1, 20'h44444, 1'b1, 1'b1);
    lookup(32'h1000_0010, 1'b0, 32'h33, "R5 invalid load");
    lookup(32'h1000_0010, 1'b1, 32'h33, "R5 invalid store");
    lookup(32'h1000_1010, 1'b1, 32'h33, "R3 global store");

    fill(10, 32'h2000_0000, 8'h01, 1'b1, 20'hAAAAA, 1'b1, 1'b1, 20'hAAAA1, 1'b1, 1'b1);
    fill(2,  32'h2000_0000, 8'h01, 1'b1, 20'hBBBBB, 1'b1, 1'b0, 20'hBBBB1, 1'b1, 1'b0);
    lookup(32'h2000_0044, 1'b0, 32'h0, "R8 lowest index wins");
    lookup(32'h2000_1044, 1'b1, 32'h0, "R8 lowest index store");
    fill(2,  32'h2200_0000, 8'h01, 1'b1, 20'hBBBBB, 1'b1, 1'b0, 20'hBBBB1, 1'b1, 1'b0);
    lookup(32'h2000_0044, 1'b0, 32'h0, "R8 R1 retag frees higher");

    // Fill and lookup in the same cycle: the lookup sees the old contents
    @(negedge clk);
    defaults();
    lk_valid = 1'b1; lk_vaddr = 32'h3000_0123; lk_write = 1'b0; lk_ctx = 32'h7;
    q.push_back(predict(32'h3000_0123, 1'b0, 32'h7, "R1 same-cycle old"));
    set_fill(12, 32'h3000_0000, 8'h07, 1'b0, 20'h55555, 1'b1, 1'b0, 20'h66666, 1'b1, 1'b0);
    model_fill(12, 32'h3000_0000, 8'h07, 1'b0, 20'h55555, 1'b1, 1'b0, 20'h66666, 1'b1, 1'b0);
    lookup(32'h3000_0123, 1'b0, 32'h7, "R1 next-cycle new");

    fill(3, 32'h0040_2000, 8'h05, 1'b0, 20'h11111, 1'b0, 1'b1, 20'h22222, 1'b1, 1'b0);
    lookup(32'h0040_2abc, 1'b0, 32'h5, "R1 rewrite invalidates");
    idle(1);
    lookup(32'h0040_3abc, 1'b0, 32'h5, "R9 after idle gap");
    idle(4);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9: %0d results missing expected 0", q.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule